// File: doc/BRIEF.md
# Region-Based Memory Access Guard

This block decides, for every memory access offered to it, whether the access may proceed. Software programs up to eight protection regions through a small register write port. Each region has a power-of-two size, a base address aligned to that size, and a valid flag. A region is cut into sixteen equal subregions. For each subregion, a per-region selector mask chooses one of two attribute sets, A or B. Each set holds access rights, a cacheable flag and a bufferable flag.

An access request carries an address, a read/write flag and a privilege flag. In the same cycle, the block returns allow or abort, a one-bit abort cause, the index of the deciding region, and the cacheable and bufferable attributes. The address passes through untranslated. A global enable bit is cleared by reset. While it is clear, every access is let through as uncacheable and unbufferable.

The register write port uses `cfg_region` to pick the region and `cfg_field` to pick the field. Field 0 holds the region word: `cfg_wdata[31:12]` is the base, `[5:1]` is the size code and `[0]` is the valid flag. Field 1 holds the 16-bit selector mask. Fields 2 and 3 hold sets A and B as `{bufferable[4], cacheable[3], perm[2:0]}`. Field 7 is the global enable in `cfg_wdata[0]`, and for that field the region index is ignored.

Top module: `prot_region_guard`

## Requirements
- R1: After synchronous active-low reset, the global enable is clear and every region is invalid. An access made after reset is allowed, with cacheable and bufferable both 0 and no abort.
- R2: While the global enable is clear, every valid access is allowed as uncacheable and unbufferable, whatever the regions hold.
- R3: `phys_addr` always equals `req_addr`.
- R4: A size code k from 11 to 31 gives a region of 2^(k+1) bytes. An address hits the region when its bits above bit k equal those of the base. A valid region whose size code is below 11 never hits.
- R5: When the block is enabled and no valid region hits, the access is aborted with `abort_cause` 0 and `hit_region` 0.
- R6: The subregion index is address bits [k:k-3]. A selector mask bit of 1 at that index picks set B; a 0 picks set A.
- R7: The permission bits are: bit 0 grants user read, bit 1 grants user write, and bit 2 grants privileged write. A privileged read is always granted in a hit region. A denied access is aborted with `abort_cause` 1 and `hit_region` set to the deciding region.
- R8: When regions overlap, the lowest-numbered valid region that hits decides the result and is reported in `hit_region`.
- R9: The decision appears in the same cycle as the request. `acc_allow` and `acc_abort` are never both high, and both are low when `req_valid` is low.
- R10: An allowed hit carries the cacheable and bufferable flags of the selected set. An aborted access reports both flags as 0.
- R11: A write through the configuration port takes effect at the next clock edge, following the field map above.
- R12: Size code 31 makes a region that covers the whole 4 GB address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 3 | Region index for the write |
| cfg_field | input | 3 | Field select (0 region word, 1 selector, 2 set A, 3 set B, 7 enable) |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| acc_allow | output | 1 | Access may proceed |
| acc_abort | output | 1 | Access is aborted; raise an exception |
| abort_cause | output | 1 | 0 = no region hit, 1 = permission violation |
| hit_region | output | 3 | Deciding region index |
| acc_cacheable | output | 1 | Access is cacheable |
| acc_bufferable | output | 1 | Access is bufferable |
| phys_addr | output | 32 | Untranslated address |

## Verification
The decision path is combinational from the request, so a wrong stored region word, selector mask or attribute set shows at the ports in the first access that touches it. It appears as a flipped allow/abort, a wrong cause, a wrong region index, or wrong attribute flags. Subregion errors show up only at the right address bits, so the bench aims accesses at neighbouring subregions on each side of a selector bit and at the first byte past a region's end. Priority errors show only where regions overlap, so an overlap between a small region and a whole-space region is probed inside and outside the small one.

// File: rtl/prg_pkg.sv
// Package: shared types and constants for the region access guard.
// Assumes a 32-bit configuration data word and 4 KB minimum base alignment.
package prg_pkg;
    localparam int unsigned PERM_W    = 3;
    localparam int unsigned PERM_UR   = 0;   // user read grant
    localparam int unsigned PERM_UW   = 1;   // user write grant
    localparam int unsigned PERM_PW   = 2;   // privileged write grant
    localparam int unsigned MIN_ALIGN = 12;  // base bits below this are zero
    localparam int unsigned MIN_K     = 11;  // smallest legal size code

    // One attribute set: {bufferable, cacheable, perm[2:0]}
    typedef struct packed {
        logic              bufferable;
        logic              cacheable;
        logic [PERM_W-1:0] perm;
    } attr_set_t;

    typedef enum logic {
        CAUSE_NO_HIT = 1'b0,
        CAUSE_PERM   = 1'b1
    } abort_cause_e;

    localparam logic [2:0] FLD_REGION = 3'd0;
    localparam logic [2:0] FLD_SELECT = 3'd1;
    localparam logic [2:0] FLD_SET_A  = 3'd2;
    localparam logic [2:0] FLD_SET_B  = 3'd3;
    localparam logic [2:0] FLD_CTRL   = 3'd7;
endpackage

// File: rtl/prg_cfg_regs.sv
// Module: configuration register bank for the region access guard.
// Holds the global enable and, per region, the base, size code, valid flag,
// selector mask and two attribute sets. Writes land on the clock edge.
// Assumes cfg_wdata is 32 bits and that AW equals the data width.
module prg_cfg_regs
    import prg_pkg::*;
#(
    parameter int unsigned NREG   = 8,
    parameter int unsigned AW     = 32,
    parameter int unsigned SIZE_W = 5,
    parameter int unsigned SUBS   = 16,
    localparam int unsigned RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [RIDX_W-1:0]             cfg_region,
    input  logic [2:0]                    cfg_field,
    input  logic [31:0]                   cfg_wdata,
    output logic                          glob_en,
    output logic [NREG-1:0]               rg_valid,
    output logic [NREG-1:0][AW-1:0]       rg_base,
    output logic [NREG-1:0][SIZE_W-1:0]   rg_size,
    output logic [NREG-1:0][SUBS-1:0]     rg_sel,
    output attr_set_t [NREG-1:0]          rg_set_a,
    output attr_set_t [NREG-1:0]          rg_set_b
);

    // Global enable: cleared by reset, written through the control field
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_en <= 1'b0;
        else if (cfg_we && cfg_field == FLD_CTRL)
            glob_en <= cfg_wdata[0];
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic wr_hit;
        assign wr_hit = cfg_we && (cfg_region == RIDX_W'(r));

        // Per-region storage: region word, selector mask, sets A and B
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rg_valid[r] <= 1'b0;
                rg_base[r]  <= '0;
                rg_size[r]  <= '0;
                rg_sel[r]   <= '0;
                rg_set_a[r] <= '0;
                rg_set_b[r] <= '0;
            end else if (wr_hit) begin
                case (cfg_field)
                    FLD_REGION: begin
                        rg_valid[r] <= cfg_wdata[0];
                        rg_size[r]  <= cfg_wdata[SIZE_W:1];
                        rg_base[r]  <= {cfg_wdata[AW-1:MIN_ALIGN], {MIN_ALIGN{1'b0}}};
                    end
                    FLD_SELECT: rg_sel[r]   <= cfg_wdata[SUBS-1:0];
                    FLD_SET_A:  rg_set_a[r] <= attr_set_t'(cfg_wdata[$bits(attr_set_t)-1:0]);
                    FLD_SET_B:  rg_set_b[r] <= attr_set_t'(cfg_wdata[$bits(attr_set_t)-1:0]);
                    default: ;
                endcase
            end
        end
    end

    // R1: the enable is clear in the first cycle after reset ends
    a_r1_enable_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !glob_en);

    // R11: an enable write is visible on the following edge
    a_r11_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_field == FLD_CTRL) |=> (glob_en == $past(cfg_wdata[0])));

endmodule

// File: rtl/prg_region_match.sv
// Module: hit detection and subregion index for a single protection region.
// A region of size code k spans 2^(k+1) bytes. Codes below MIN_K never hit.
// Assumes the base is aligned to the region size.
module prg_region_match
    import prg_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned SIZE_W = 5,
    parameter int unsigned SUB_W  = 4,
    localparam int unsigned SH_W  = SIZE_W + 1
) (
    input  logic              valid,
    input  logic [AW-1:0]     base,
    input  logic [SIZE_W-1:0] size,
    input  logic [AW-1:0]     addr,
    output logic              hit,
    output logic [SUB_W-1:0]  sub_idx
);

    logic [AW-1:0]   diff;
    logic [SH_W-1:0] top_sh;
    logic [SH_W-1:0] sub_sh;
    logic            legal;

    // Compare the address bits above the region boundary and extract the subregion index
    always_comb begin
        diff    = addr ^ base;
        top_sh  = {1'b0, size} + SH_W'(1);
        sub_sh  = {1'b0, size} - SH_W'(SUB_W - 1);
        legal   = valid && (size >= SIZE_W'(MIN_K));
        hit     = legal && ((diff >> top_sh) == '0);
        sub_idx = SUB_W'(addr >> sub_sh);
    end

endmodule

// File: rtl/prg_decide.sv
// Module: priority pick and permission check for the region access guard.
// The lowest-numbered hitting region wins. Its selector bit at the subregion
// index picks set A or set B. Assumes the hit vector and indices are valid
// in the same cycle as the request.
module prg_decide
    import prg_pkg::*;
#(
    parameter int unsigned NREG  = 8,
    parameter int unsigned SUBS  = 16,
    parameter int unsigned SUB_W = 4,
    localparam int unsigned RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_priv,
    input  logic [NREG-1:0]              hit_vec,
    input  logic [NREG-1:0][SUB_W-1:0]   sub_idx,
    input  logic [NREG-1:0][SUBS-1:0]    rg_sel,
    input  attr_set_t [NREG-1:0]         rg_set_a,
    input  attr_set_t [NREG-1:0]         rg_set_b,
    output logic                         allow,
    output logic                         abort,
    output abort_cause_e                 cause,
    output logic [RIDX_W-1:0]            region,
    output logic                         cacheable,
    output logic                         bufferable
);

    logic [RIDX_W-1:0] win;
    logic              found;
    attr_set_t         attr;
    logic              granted;

    // Priority pick: scan downward so the lowest hitting index is kept last
    always_comb begin
        win   = '0;
        found = 1'b0;
        for (int r = NREG - 1; r >= 0; r--) begin
            if (hit_vec[r]) begin
                win   = RIDX_W'(r);
                found = 1'b1;
            end
        end
    end

    // Attribute set choice and permission test for the winning region
    always_comb begin
        attr = rg_sel[win][sub_idx[win]] ? rg_set_b[win] : rg_set_a[win];
        if (req_write)
            granted = req_priv ? attr.perm[PERM_PW] : attr.perm[PERM_UW];
        else
            granted = req_priv ? 1'b1 : attr.perm[PERM_UR];
    end

    // Final decision and attribute outputs
    always_comb begin
        allow      = 1'b0;
        abort      = 1'b0;
        cause      = CAUSE_NO_HIT;
        region     = '0;
        cacheable  = 1'b0;
        bufferable = 1'b0;
        if (req_valid) begin
            if (!en) begin
                allow = 1'b1;
            end else if (!found) begin
                abort = 1'b1;
            end else if (!granted) begin
                abort  = 1'b1;
                cause  = CAUSE_PERM;
                region = win;
            end else begin
                allow      = 1'b1;
                region     = win;
                cacheable  = attr.cacheable;
                bufferable = attr.bufferable;
            end
        end
    end

    // R9: allow and abort are mutually exclusive, both low when idle
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(allow && abort) && (req_valid || (!allow && !abort)));

    // R2: a disabled block lets every request through as plain memory
    a_r2_disabled_open: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !en) |-> (allow && !cacheable && !bufferable));

    // R5: a no-hit cause only when no region hit at all
    a_r5_nohit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && cause == CAUSE_NO_HIT) |-> (hit_vec == '0));

    // R8: the reported region hit and no lower region did
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (allow && en) |-> (hit_vec[region] &&
            ((hit_vec & ((NREG'(1) << region) - NREG'(1))) == '0)));

    // R10: aborted accesses carry no attributes
    a_r10_abort_no_attr: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!cacheable && !bufferable));

endmodule

// File: rtl/prot_region_guard.sv
// Module: top of the region access guard. It ties the configuration bank, one
// match unit per region, and the decision logic together. The request path is
// combinational and the configuration is registered.
// Assumes a 32-bit address and data word.
module prot_region_guard
    import prg_pkg::*;
#(
    parameter int unsigned NREG   = 8,
    parameter int unsigned AW     = 32,
    parameter int unsigned SIZE_W = 5,
    parameter int unsigned SUB_W  = 4,
    localparam int unsigned SUBS   = 1 << SUB_W,
    localparam int unsigned RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_region,
    input  logic [2:0]        cfg_field,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic              req_priv,
    output logic              acc_allow,
    output logic              acc_abort,
    output logic              abort_cause,
    output logic [RIDX_W-1:0] hit_region,
    output logic              acc_cacheable,
    output logic              acc_bufferable,
    output logic [AW-1:0]     phys_addr
);

    logic                        glob_en;
    logic [NREG-1:0]             rg_valid;
    logic [NREG-1:0][AW-1:0]     rg_base;
    logic [NREG-1:0][SIZE_W-1:0] rg_size;
    logic [NREG-1:0][SUBS-1:0]   rg_sel;
    attr_set_t [NREG-1:0]        rg_set_a;
    attr_set_t [NREG-1:0]        rg_set_b;
    logic [NREG-1:0]             hit_vec;
    logic [NREG-1:0][SUB_W-1:0]  sub_idx;
    abort_cause_e                cause;

    prg_cfg_regs #(
        .NREG(NREG), .AW(AW), .SIZE_W(SIZE_W), .SUBS(SUBS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .glob_en(glob_en),
        .rg_valid(rg_valid), .rg_base(rg_base), .rg_size(rg_size),
        .rg_sel(rg_sel), .rg_set_a(rg_set_a), .rg_set_b(rg_set_b)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_match
        prg_region_match #(
            .AW(AW), .SIZE_W(SIZE_W), .SUB_W(SUB_W)
        ) u_match (
            .valid(rg_valid[r]), .base(rg_base[r]), .size(rg_size[r]),
            .addr(req_addr), .hit(hit_vec[r]), .sub_idx(sub_idx[r])
        );
    end

    prg_decide #(
        .NREG(NREG), .SUBS(SUBS), .SUB_W(SUB_W)
    ) u_decide (
        .clk(clk), .rst_n(rst_n), .en(glob_en), .req_valid(req_valid),
        .req_write(req_write), .req_priv(req_priv), .hit_vec(hit_vec),
        .sub_idx(sub_idx), .rg_sel(rg_sel), .rg_set_a(rg_set_a),
        .rg_set_b(rg_set_b), .allow(acc_allow), .abort(acc_abort),
        .cause(cause), .region(hit_region), .cacheable(acc_cacheable),
        .bufferable(acc_bufferable)
    );

    assign abort_cause = cause;
    assign phys_addr   = req_addr;

    // R3: the address leaves untranslated
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr == req_addr);

endmodule

// File: tb/prot_region_guard_tb.sv
// Directed bench for the region access guard. Each scenario is a task that checks its own results.
module prot_region_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_region = '0;
    logic [2:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic        acc_allow, acc_abort, abort_cause, acc_cacheable, acc_bufferable;
    logic [2:0]  hit_region;
    logic [31:0] phys_addr;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;  // 50 MHz

    prot_region_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_priv(req_priv),
        .acc_allow(acc_allow), .acc_abort(acc_abort), .abort_cause(abort_cause),
        .hit_region(hit_region), .acc_cacheable(acc_cacheable),
        .acc_bufferable(acc_bufferable), .phys_addr(phys_addr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] rword(input logic [31:0] base, input int k, input bit v);
        return (base & 32'hFFFF_F000) | (32'(k) << 1) | 32'(v);
    endfunction

    task automatic cfg(input int r, input int f, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = r[2:0]; cfg_field = f[2:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Outcome packed as {allow, abort, cause, region[2:0], cacheable, bufferable}
    task automatic acc(input string tag, input logic [31:0] a, input bit wr, input bit pv,
                       input logic [7:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_priv = pv;
        #5;
        chk(tag, {24'd0, acc_allow, acc_abort, abort_cause, hit_region,
                  acc_cacheable, acc_bufferable}, {24'd0, exp});
        chk({tag, " R3 addr"}, phys_addr, a);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [7:0] o(input bit al, input bit ab, input bit c,
                                     input int rg, input bit ca, input bit bu);
        return {al, ab, c, rg[2:0], ca, bu};
    endfunction

    task automatic t_reset();  // R1
        acc("R1 after reset", 32'h1234_5678, 1'b1, 1'b0, o(1, 0, 0, 0, 0, 0));
    endtask

    task automatic t_disabled();  // R2, R11
        cfg(0, 0, rword(32'h1000_0000, 12, 1));
        cfg(0, 1, 32'h0000_0020);
        cfg(0, 2, 32'h09);
        cfg(0, 3, 32'h13);
        acc("R2 disabled hit", 32'h1000_0800, 1'b1, 1'b0, o(1, 0, 0, 0, 0, 0));
        acc("R2 disabled miss", 32'h7000_0000, 1'b0, 1'b0, o(1, 0, 0, 0, 0, 0));
    endtask

    task automatic t_nohit();  // R4, R5, R11
        cfg(0, 7, 32'h1);
        acc("R5 far miss", 32'h2000_0000, 1'b0, 1'b0, o(0, 1, 0, 0, 0, 0));
        acc("R4 last byte", 32'h1000_1FFC, 1'b0, 1'b0, o(1, 0, 0, 0, 1, 0));
        acc("R4 one past end", 32'h1000_2000, 1'b0, 1'b0, o(0, 1, 0, 0, 0, 0));
        acc("R4 one below base", 32'h0FFF_FFFC, 1'b0, 1'b0, o(0, 1, 0, 0, 0, 0));
    endtask

    task automatic t_subregion();  // R6, R7, R10
        acc("R6 set B user write", 32'h1000_0A00, 1'b1, 1'b0, o(1, 0, 0, 0, 0, 1));
        acc("R7 set A user write denied", 32'h1000_0800, 1'b1, 1'b0, o(0, 1, 1, 0, 0, 0));
        acc("R10 set A user read", 32'h1000_0800, 1'b0, 1'b0, o(1, 0, 0, 0, 1, 0));
        acc("R6 top subregion", 32'h1000_1E00, 1'b0, 1'b0, o(1, 0, 0, 0, 1, 0));
        acc("R6 below sel bit", 32'h1000_09FC, 1'b1, 1'b0, o(0, 1, 1, 0, 0, 0));
    endtask

    task automatic t_priv();  // R7
        acc("R7 priv read", 32'h1000_0800, 1'b0, 1'b1, o(1, 0, 0, 0, 1, 0));
        acc("R7 priv write denied", 32'h1000_0800, 1'b1, 1'b1, o(0, 1, 1, 0, 0, 0));
        cfg(0, 2, 32'h0D);
        acc("R7 priv write granted", 32'h1000_0800, 1'b1, 1'b1, o(1, 0, 0, 0, 1, 0));
        acc("R7 user read still ok", 32'h1000_0800, 1'b0, 1'b0, o(1, 0, 0, 0, 1, 0));
        acc("R7 user write still denied", 32'h1000_0800, 1'b1, 1'b0, o(0, 1, 1, 0, 0, 0));
    endtask

    task automatic t_overlap();  // R8, R12
        cfg(0, 0, 32'h0);
        cfg(3, 0, rword(32'h0, 31, 1));
        cfg(3, 2, 32'h0F);
        cfg(1, 0, rword(32'h1000_0000, 12, 1));
        acc("R8 lower region decides", 32'h1000_0000, 1'b0, 1'b0, o(0, 1, 1, 1, 0, 0));
        acc("R12 whole space", 32'h5000_0000, 1'b1, 1'b0, o(1, 0, 0, 3, 1, 0));
        acc("R12 top address", 32'hFFFF_FFFC, 1'b0, 1'b0, o(1, 0, 0, 3, 1, 0));
    endtask

    task automatic t_small_size();  // R4
        cfg(3, 0, 32'h0);
        cfg(1, 0, 32'h0);
        cfg(2, 0, rword(32'h3000_0000, 5, 1));
        cfg(2, 2, 32'h07);
        acc("R4 illegal size never hits", 32'h3000_0000, 1'b0, 1'b0, o(0, 1, 0, 0, 0, 0));
        cfg(2, 0, rword(32'h3000_0000, 11, 1));
        acc("R4 smallest region hit", 32'h3000_0FFF, 1'b1, 1'b0, o(1, 0, 0, 2, 0, 0));
        acc("R4 smallest region end", 32'h3000_1000, 1'b1, 1'b0, o(0, 1, 0, 0, 0, 0));
    endtask

    task automatic t_idle();  // R9
        @(negedge clk);
        req_valid = 1'b0; req_addr = 32'h3000_0000;
        #5;
        chk("R9 idle no decision", {30'd0, acc_allow, acc_abort}, 32'd0);
    endtask

    task automatic t_disable_again();  // R2, R11
        cfg(0, 7, 32'h0);
        acc("R2 disabled again", 32'h9000_0000, 1'b1, 1'b0, o(1, 0, 0, 0, 0, 0));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_nohit();
        t_subregion();
        t_priv();
        t_overlap();
        t_small_size();
        t_idle();
        t_disable_again();
        summary();
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule